// File: doc/BRIEF.md
# Sync Pulse Timestamp Capture Unit

This block keeps a local time base for a controller whose 25 MHz clock is steered by a software phase-locked loop. The time base is a free-running counter whose cycle is 500000 clock periods, which is 20 ms, one period of a 50 Hz timing reference. Two asynchronous events can arrive: a low-jitter external sync pulse and a network interrupt raised by timing packets. Each event is synchronised and edge-detected. Its rising edge copies the counter into a capture register of its own.

Software reads the two captures to work out the phase error of the local clock. Each capture carries a stale flag, so software can tell a fresh timestamp from one it has already consumed. Software also programs a target count. Each time the counter passes that value, an internal sync pulse is produced. A reset flag shows whether software has programmed the target since reset.

The register port is a plain single-cycle bus. Read data is combinational from the address, and a read strobe marks the addressed capture as consumed at the next clock edge. The register map is: address 0 holds the external capture, address 1 the network capture, address 2 the target, and address 3 reads as zero.

Top module: `sync_stamp_unit`

## Requirements
- R1: The counter starts at 0 after reset, advances by one every clock, and returns to 0 after reaching PERIOD-1 (default PERIOD 500000, CNT_W 20). A capture taken while the counter wraps reads 0.
- R2: A capture register read returns the captured count in bits 31:(32-CNT_W), which is 31:12 by default. Bits (31-CNT_W):1 read 0 and bit 0 is the stale flag.
- R3: A rising edge on `ext_sync_i` loads the address-0 capture with the counter value reached one clock after the clock edge that first samples the input high. The new value is readable from the cycle after that. An input held high triggers no further capture.
- R4: A rising edge on `net_irq_i` loads the address-1 capture with the same timing as R3, independently of the external channel.
- R5: A stale flag reads 1 after reset and drops to 0 when its register captures. It rises to 1 at the clock edge where `rd_en_i` is high with that register's address.
- R6: If a capture and a read strobe hit the same register at the same clock edge, the new value is stored and the stale flag ends at 0.
- R7: A write with `wr_en_i` high to address 2 stores `wdata_i[31:32-CNT_W]` as the target. Address 2 reads back the target in the same field position, with the reset flag in bit 0. The reset flag is 1 after reset and 0 from the first write to address 2 onward. Writes to addresses 0, 1 and 3 have no effect, and address 3 reads 0.
- R8: `int_sync_o` is high exactly in the cycles where the counter equals the target, and only once the reset flag is 0. A target of PERIOD or above never produces a pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 25 MHz disciplined clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_sync_i | input | 1 | External sync pulse, asynchronous |
| net_irq_i | input | 1 | Network timing interrupt, asynchronous |
| addr_i | input | 2 | Register address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe, marks the addressed capture consumed |
| rdata_o | output | 32 | Read data for `addr_i` |
| int_sync_o | output | 1 | Internal sync pulse, one cycle per counter match |

## Verification
The bench builds the unit with CNT_W kept at 20, so the field positions match the default layout, and with PERIOD reduced to 50. The short period lets the counter wrap dozens of times in a few thousand cycles. Captures then land on both sides of the wrap point, programmed targets are met repeatedly, and a target set beyond PERIOD can be shown never to fire. Directed sequences place a capture exactly on the wrap and line up an edge with a read strobe at the same clock edge.

// File: rtl/sync_stamp_pkg.sv
package sync_stamp_pkg;
  localparam int REG_W = 32;
  localparam int N_CH  = 2;

  typedef enum logic [1:0] {
    ADDR_EXT  = 2'd0,
    ADDR_NET  = 2'd1,
    ADDR_TGT  = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/sync_stamp_edge.sv
module sync_stamp_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  // q[STAGES-1] is the synchronised level, q[STAGES] its previous value
  logic [STAGES:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= {q[STAGES-1:0], async_i};
  end

  assign rise_o = q[STAGES-1] & ~q[STAGES];
endmodule

// File: rtl/sync_stamp_timebase.sv
module sync_stamp_timebase #(
  parameter int CNT_W  = 20,
  parameter int PERIOD = 500000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_o <= '0;
    else if (cnt_o == LAST) cnt_o <= '0;
    else                    cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/sync_stamp_capture.sv
module sync_stamp_capture #(
  parameter int CNT_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             trig_i,
  input  logic             read_i,
  output logic [CNT_W-1:0] value_o,
  output logic             stale_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      value_o <= '0;
      stale_o <= 1'b1;
    end else if (trig_i) begin
      // capture wins over a simultaneous read
      value_o <= cnt_i;
      stale_o <= 1'b0;
    end else if (read_i) begin
      stale_o <= 1'b1;
    end
  end
endmodule

// File: rtl/sync_stamp_unit.sv
module sync_stamp_unit
  import sync_stamp_pkg::*;
#(
  parameter int CNT_W  = 20,
  parameter int PERIOD = 500000,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_sync_i,
  input  logic             net_irq_i,
  input  logic [1:0]       addr_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             rd_en_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             int_sync_o
);
  localparam int PAD = REG_W - CNT_W - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [N_CH-1:0]  ev_in;
  logic [N_CH-1:0]  rise;
  logic [N_CH-1:0]  stale;
  logic [CNT_W-1:0] cap [N_CH];
  logic [CNT_W-1:0] tgt_q;
  logic             rst_flag_q;
  logic             unused_wdata;

  assign ev_in        = {net_irq_i, ext_sync_i};
  assign unused_wdata = ^wdata_i[PAD:0];

  sync_stamp_timebase #(.CNT_W(CNT_W), .PERIOD(PERIOD)) i_timebase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_o  (cnt_q)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    sync_stamp_edge #(.STAGES(STAGES)) i_edge (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (ev_in[g]),
      .rise_o  (rise[g])
    );
    sync_stamp_capture #(.CNT_W(CNT_W)) i_cap (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cnt_i   (cnt_q),
      .trig_i  (rise[g]),
      .read_i  (rd_en_i && (addr_i == 2'(g))),
      .value_o (cap[g]),
      .stale_o (stale[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q      <= '0;
      rst_flag_q <= 1'b1;
    end else if (wr_en_i && addr_i == ADDR_TGT) begin
      tgt_q      <= wdata_i[REG_W-1 -: CNT_W];
      rst_flag_q <= 1'b0;
    end
  end

  assign int_sync_o = !rst_flag_q && (cnt_q == tgt_q);

  always_comb begin
    case (addr_i)
      ADDR_EXT: rdata_o = {cap[0], {PAD{1'b0}}, stale[0]};
      ADDR_NET: rdata_o = {cap[1], {PAD{1'b0}}, stale[1]};
      ADDR_TGT: rdata_o = {tgt_q,  {PAD{1'b0}}, rst_flag_q};
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/sync_stamp_chk.sv
module sync_stamp_chk #(
  parameter int CNT_W  = 20,
  parameter int PERIOD = 500000
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] cnt,
  input logic [1:0]       rise,
  input logic [1:0]       stale,
  input logic             rd_en,
  input logic             wr_en,
  input logic [1:0]       addr,
  input logic             rst_flag,
  input logic             int_sync
);
  // R1
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt < CNT_W'(PERIOD));
  // R1
  cnt_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == CNT_W'(PERIOD - 1)) |=> (cnt == '0));
  // R5
  ext_fresh_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise[0] |=> !stale[0]);
  // R5
  ext_consumed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en && addr == 2'd0 && !rise[0]) |=> stale[0]);
  // R6
  net_collide_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise[1] && rd_en && addr == 2'd1) |=> !stale[1]);
  // R7
  rst_flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_flag |=> !rst_flag);
  // R7
  rst_flag_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_flag) |-> $past(wr_en && addr == 2'd2));
  // R8
  int_sync_armed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_sync |-> !rst_flag);
endmodule

bind sync_stamp_unit sync_stamp_chk #(.CNT_W(CNT_W), .PERIOD(PERIOD)) i_sync_stamp_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cnt      (cnt_q),
  .rise     (rise),
  .stale    (stale),
  .rd_en    (rd_en_i),
  .wr_en    (wr_en_i),
  .addr     (addr_i),
  .rst_flag (rst_flag_q),
  .int_sync (int_sync_o)
);

// File: tb/test_sync_stamp_unit.sv
`timescale 1ns/1ps
module test_sync_stamp_unit;
  localparam int CW = 20;
  localparam int P  = 50;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_sync = 1'b0, net_irq = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        int_sync;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  bit live = 1'b0;

  always #2 clk = ~clk;

  sync_stamp_unit #(.CNT_W(CW), .PERIOD(P)) i_sync_stamp_unit (
    .clk_i(clk), .rst_ni(rst_n), .ext_sync_i(ext_sync), .net_irq_i(net_irq),
    .addr_i(addr), .wr_en_i(wr_en), .wdata_i(wdata), .rd_en_i(rd_en),
    .rdata_o(rdata), .int_sync_o(int_sync)
  );

  // behavioural reference
  int m_cnt, m_tgt;
  bit m_armed;
  int m_cap [2];
  bit m_stale [2];
  bit m_lat [2][$];   // input samples, newest at back

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_tgt = 0; m_armed = 0;
      for (int c = 0; c < 2; c++) begin
        m_cap[c] = 0; m_stale[c] = 1;
        m_lat[c] = '{0, 0, 0};
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        // level two samples back high, three samples back low
        if (m_lat[c][1] && !m_lat[c][0]) begin
          m_cap[c] = m_cnt; m_stale[c] = 0;
        end else if (rd_en && addr == 2'(c)) begin
          m_stale[c] = 1;
        end
        void'(m_lat[c].pop_front());
        m_lat[c].push_back(c == 0 ? ext_sync : net_irq);
      end
      if (wr_en && addr == 2'd2) begin
        m_tgt = int'(wdata[31:12]); m_armed = 1;
      end
      m_cnt = (m_cnt == P - 1) ? 0 : m_cnt + 1;
    end
  end

  function automatic logic [31:0] m_rdata(logic [1:0] a);
    case (a)
      2'd0: return {CW'(m_cap[0]), 11'b0, m_stale[0]};
      2'd1: return {CW'(m_cap[1]), 11'b0, m_stale[1]};
      2'd2: return {CW'(m_tgt), 11'b0, !m_armed};
      default: return '0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (live && rst_n && !done) begin
      case (addr)
        2'd0: chk("R3", rdata, m_rdata(addr));
        2'd1: chk("R4", rdata, m_rdata(addr));
        default: chk("R7", rdata, m_rdata(addr));
      endcase
      chk("R8", 32'(int_sync), 32'(m_armed && (m_cnt == m_tgt)));
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  logic [31:0] lfsr = 32'h1ACE_B00C;
  function automatic logic [31:0] nxt(logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  initial begin
    step(3);
    rst_n = 1'b1;
    live = 1'b1;
    @(negedge clk);
    // reset state
    addr = 2'd0; #0.1;
    chk("R5", rdata, 32'h0000_0001);
    addr = 2'd2; #0.1;
    chk("R7", rdata, 32'h0000_0001);
    chk("R8", 32'(int_sync), 32'd0);

    // writes to non-target addresses are ignored
    step();
    addr = 2'd0; wr_en = 1; wdata = 32'hFFFF_FFFF;
    step();
    addr = 2'd3;
    step();
    wr_en = 0; addr = 2'd0;
    @(negedge clk);
    chk("R7", rdata, 32'h0000_0001);

    // capture at the wrap point
    step(4);
    while (m_cnt != P - 2) step();
    ext_sync = 1;
    step(3);
    @(negedge clk);
    chk("R1", rdata, 32'h0000_0000);
    step(5);
    @(negedge clk);
    chk("R3", rdata, 32'h0000_0000);   // held level: no new capture
    step();
    rd_en = 1;
    step();
    rd_en = 0;
    @(negedge clk);
    chk("R5", rdata, 32'h0000_0001);
    chk("R2", 32'(rdata[11:1]), 32'd0);

    // capture and read at the same edge
    ext_sync = 0;
    step(4);
    ext_sync = 1;
    step(2);
    rd_en = 1; addr = 2'd0;
    step();
    rd_en = 0;
    @(negedge clk);
    chk("R6", 32'(rdata[0]), 32'd0);
    chk("R6", rdata, m_rdata(2'd0));
    ext_sync = 0;

    // program a target and watch it fire
    step();
    addr = 2'd2; wr_en = 1; wdata = {20'd7, 12'hABC};
    step();
    wr_en = 0;
    @(negedge clk);
    chk("R7", rdata, {20'd7, 12'h000});
    while (m_cnt != 7) step();
    @(negedge clk);
    chk("R8", 32'(int_sync), 32'd1);

    // mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      lfsr = nxt(lfsr);
      if (lfsr[3:0] == 4'd0) ext_sync = ~ext_sync;
      if (lfsr[7:4] == 4'd1) net_irq = ~net_irq;
      addr  = lfsr[9:8];
      rd_en = lfsr[10] & lfsr[11];
      wr_en = (lfsr[17:12] == 6'd3);
      wdata = {20'(int'(lfsr[31:26]) % (P + 6)), lfsr[23:12]};
      step();
      if (addr == 2'd0) begin
        @(negedge clk);
        chk("R2", 32'(rdata[11:1]), 32'd0);
      end
    end
    wr_en = 0; rd_en = 0;

    // out-of-range target never fires
    addr = 2'd2; wr_en = 1; wdata = {20'(P + 3), 12'h0};
    step();
    wr_en = 0;
    for (int i = 0; i < 2 * P; i++) begin
      @(negedge clk);
      chk("R8", 32'(int_sync), 32'd0);
      step();
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule